// File: doc/BRIEF.md
# Narrow-Word Compressed Cache Array

This block is the storage and lookup core of a small set-associative level-one data cache. It can keep two lines in the space of one. When a line arrives from the next level, the block checks every 32-bit word in it. If each word is a sign-extended 16-bit value, only the low halves are kept. Two such compressed lines can share one physical block, each with its own tag slot. A line with any wide word occupies a whole physical block in the usual way.

A per-block width bit steers the read path. For a compressed block, the selected word slot supplies a 16-bit half, which is sign-extended to 32 bits. For a normal block, the full word is returned. The word index taken from the address picks the same word slot in both cases, so the byte offset is never rewritten.

Replacement is ranked by the most recently used line held in each physical block. A compressed block therefore counts as young when either of its two lines is young.

Top module: `nwc_cache`

Address fields at the default parameters are: byte offset in bits [1:0], word index in bits [4:2], set index in bits [8:5], and tag in bits [31:9]. Fill line word i is taken from `fill_data[32*i+31 : 32*i]`.

## Requirements
- R1: A word is narrow when its signed value lies in -32768..32767. A filled line is stored compressed (width bit set) only when all of its words are narrow. A single wide word, such as 0x00008000 or 0xFFFF7FFF, makes the line normal, and that word reads back unchanged.
- R2: In a compressed block, the first line stored holds the low 16 bits of each word slot and uses tag slot 0. The second line holds the high 16 bits and uses tag slot 1. The word index in bits [4:2] selects the same slot for both lines, and both lines stay readable together.
- R3: A hit on a compressed line returns the stored half sign-extended to 32 bits. A hit on a normal line returns the full 32-bit word.
- R4: A normal block uses tag slot 0 only, and its tag slot 1 is always invalid. Storing a normal line over a compressed block drops both compressed lines.
- R5: A load hits only when a valid tag slot in the addressed set holds the address tag. On a miss, `load_hit` is 0 and `load_data` is 0.
- R6: The result of a load appears on the cycle after `load_valid`, with `load_done` high. A fill is visible to loads issued from the next cycle on. A load issued in the same cycle as a fill sees the contents from before the fill.
- R7: A compressed fill goes into the first free tag slot (lowest way first, then lowest slot) of a block whose width bit is already set. If no such slot exists, it takes a physical block chosen as in R8, sets that block's width bit, uses slot 0 and invalidates slot 1. A line already packed into a block is kept when its mate is added.
- R8: A new physical block is chosen as follows. The lowest-numbered empty way wins. If no way is empty, the way whose most recently used resident line is least recent is chosen.
- R9: A fill, or a load hit issued without a fill in the same cycle, makes the accessed line the most recent in its set. A load hit that coincides with a fill leaves the recency order unchanged.
- R10: After reset, all lines are invalid, all width bits are clear, and `load_done` and `load_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | Store the line on `fill_data` this cycle |
| fill_addr | input | 32 | Address of the line being filled |
| fill_data | input | 256 | Eight 32-bit words, word 0 in the low bits |
| load_valid | input | 1 | Look up `load_addr` this cycle |
| load_addr | input | 32 | Load address |
| load_done | output | 1 | A load result is presented this cycle |
| load_hit | output | 1 | The presented load hit |
| load_data | output | 32 | Loaded word, zero on a miss |

## Verification
The hardest case to reach from the ports is a replacement decision that depends on the recency of two lines packed into the same block. The harder variant is one where a load hit lands in the same cycle as a fill. To reach it, the stimulus first builds a set containing one full compressed block and one normal block. It then touches specific lines in a chosen order and fills while loading, so that the next victim changes depending on whether the coinciding hit was counted. A long random phase follows. It confines traffic to two sets and six tags, mixes narrow lines, wide lines and edge words such as 0x00008000 and 0xFFFF8000, and compares every cycle against a behavioural model that uses time stamps.

// File: rtl/nwc_pkg.sv
`timescale 1ns/1ps
package nwc_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int SLOTS  = 2;

  // 16-bit value widened by copying its top bit
  function automatic logic [WORD_W-1:0] sext_half(input logic [HALF_W-1:0] h);
    return {{(WORD_W-HALF_W){h[HALF_W-1]}}, h};
  endfunction

  // a word is narrow when widening its low half rebuilds it exactly
  function automatic logic word_is_narrow(input logic [WORD_W-1:0] w);
    return sext_half(w[HALF_W-1:0]) == w;
  endfunction
endpackage

// File: rtl/nwc_narrow_chk.sv
`timescale 1ns/1ps
module nwc_narrow_chk
  import nwc_pkg::*;
#(
  parameter int LINE_WORDS = 8
) (
  input  logic [LINE_WORDS*WORD_W-1:0] line_in,
  output logic                         line_narrow,
  output logic [LINE_WORDS*HALF_W-1:0] halves
);
  logic [LINE_WORDS-1:0] word_ok;

  for (genvar i = 0; i < LINE_WORDS; i++) begin : g_word
    assign word_ok[i] = word_is_narrow(line_in[i*WORD_W +: WORD_W]);
    assign halves[i*HALF_W +: HALF_W] = line_in[i*WORD_W +: HALF_W];
  end

  assign line_narrow = &word_ok;
endmodule

// File: rtl/nwc_tag_match.sv
`timescale 1ns/1ps
module nwc_tag_match #(
  parameter int NL    = 4,
  parameter int TAG_W = 23
) (
  input  logic [NL-1:0][TAG_W-1:0] tags,
  input  logic [NL-1:0]            valid,
  input  logic [TAG_W-1:0]         look_tag,
  output logic                     hit,
  output logic [$clog2(NL)-1:0]    hit_line
);
  localparam int LN_W = $clog2(NL);
  logic [NL-1:0] match_vec;

  for (genvar l = 0; l < NL; l++) begin : g_cmp
    assign match_vec[l] = valid[l] && (tags[l] == look_tag);
  end

  always_comb begin
    hit_line = '0;
    for (int l = NL-1; l >= 0; l--)
      if (match_vec[l]) hit_line = LN_W'(l);
  end

  assign hit = |match_vec;
endmodule

// File: rtl/nwc_recency.sv
`timescale 1ns/1ps
module nwc_recency #(
  parameter int SETS  = 16,
  parameter int WAYS  = 2,
  parameter int SLOTS = 2,
  localparam int NL    = WAYS*SLOTS,
  localparam int LN_W  = $clog2(NL),
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [LN_W-1:0]  touch_line,
  input  logic [SET_W-1:0] sel_set,
  input  logic [NL-1:0]    sel_valid,
  output logic [WAY_W-1:0] victim_way
);
  // rank 0 = most recent, NL-1 = least recent; always a permutation per set
  logic [NL-1:0][LN_W-1:0] rank_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int l = 0; l < NL; l++)
          rank_q[s][l] <= LN_W'(l);
    end else if (touch_en) begin
      for (int l = 0; l < NL; l++) begin
        if (LN_W'(l) == touch_line)
          rank_q[touch_set][l] <= '0;
        else if (rank_q[touch_set][l] < rank_q[touch_set][touch_line])
          rank_q[touch_set][l] <= rank_q[touch_set][l] + 1'b1;
      end
    end
  end

  // age of each physical block = rank of its youngest valid line
  logic [WAYS-1:0][LN_W-1:0] mru_age;
  logic [WAYS-1:0]           blk_empty;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      mru_age[w]   = '1;
      blk_empty[w] = 1'b1;
      for (int s = 0; s < SLOTS; s++) begin
        if (sel_valid[w*SLOTS+s]) begin
          blk_empty[w] = 1'b0;
          if (rank_q[sel_set][w*SLOTS+s] < mru_age[w])
            mru_age[w] = rank_q[sel_set][w*SLOTS+s];
        end
      end
    end
  end

  logic            pick_empty;
  logic [LN_W-1:0] best_age;

  always_comb begin
    victim_way = '0;
    pick_empty = 1'b0;
    best_age   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (blk_empty[w] && !pick_empty) begin
        pick_empty = 1'b1;
        victim_way = WAY_W'(w);
      end
    end
    if (!pick_empty) begin
      for (int w = 0; w < WAYS; w++) begin
        if (w == 0 || mru_age[w] > best_age) begin
          best_age   = mru_age[w];
          victim_way = WAY_W'(w);
        end
      end
    end
  end

  // ranks of every set stay a permutation
  logic [SETS-1:0] perm_ok;
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      logic [NL-1:0] seen;
      seen = '0;
      for (int l = 0; l < NL; l++) seen[rank_q[s][l]] = 1'b1;
      perm_ok[s] = &seen;
    end
  end

  assert_rank_perm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    &perm_ok);

  assert_touch_newest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> rank_q[$past(touch_set)][$past(touch_line)] == '0);
endmodule

// File: rtl/nwc_cache.sv
`timescale 1ns/1ps
module nwc_cache
  import nwc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int WAYS       = 2,
  parameter int SETS       = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fill_valid,
  input  logic [ADDR_W-1:0]            fill_addr,
  input  logic [LINE_WORDS*WORD_W-1:0] fill_data,
  input  logic                         load_valid,
  input  logic [ADDR_W-1:0]            load_addr,
  output logic                         load_done,
  output logic                         load_hit,
  output logic [WORD_W-1:0]            load_data
);
  localparam int BYTE_W = $clog2(WORD_W/8);
  localparam int IDX_W  = $clog2(LINE_WORDS);
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - BYTE_W - IDX_W - SET_W;
  localparam int NL     = WAYS*SLOTS;
  localparam int LN_W   = $clog2(NL);
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int SLOT_W = $clog2(SLOTS);

  // ---------------- storage ----------------
  logic [TAG_W-1:0]  tag_q [SETS][NL];
  logic [NL-1:0]     vld_q [SETS];
  logic [WAYS-1:0]   wid_q [SETS];
  logic [WORD_W-1:0] dat_q [SETS][WAYS][LINE_WORDS];

  // ---------------- fill side ----------------
  logic [SET_W-1:0] f_set;
  logic [TAG_W-1:0] f_tag;
  assign f_set = fill_addr[BYTE_W+IDX_W +: SET_W];
  assign f_tag = fill_addr[ADDR_W-1 -: TAG_W];

  logic                         fill_narrow;
  logic [LINE_WORDS*HALF_W-1:0] fill_halves;

  nwc_narrow_chk #(.LINE_WORDS(LINE_WORDS)) u_narrow (
    .line_in     (fill_data),
    .line_narrow (fill_narrow),
    .halves      (fill_halves)
  );

  // free compressed slot in a block already holding narrow lines
  logic              pack_found;
  logic [WAY_W-1:0]  pack_way;
  logic [SLOT_W-1:0] pack_slot;

  always_comb begin
    pack_found = 1'b0;
    pack_way   = '0;
    pack_slot  = '0;
    for (int w = 0; w < WAYS; w++)
      for (int s = 0; s < SLOTS; s++)
        if (!pack_found && wid_q[f_set][w] && !vld_q[f_set][w*SLOTS+s]) begin
          pack_found = 1'b1;
          pack_way   = WAY_W'(w);
          pack_slot  = SLOT_W'(s);
        end
  end

  // named events for the checks below
  logic ev_fill_pack, ev_fill_new_cmp, ev_fill_norm;
  assign ev_fill_pack    = fill_valid &&  fill_narrow &&  pack_found;
  assign ev_fill_new_cmp = fill_valid &&  fill_narrow && !pack_found;
  assign ev_fill_norm    = fill_valid && !fill_narrow;

  logic [WAY_W-1:0]  victim_way, fill_way;
  logic [SLOT_W-1:0] fill_slot;
  logic [LN_W-1:0]   fill_line;

  assign fill_way  = ev_fill_pack ? pack_way  : victim_way;
  assign fill_slot = ev_fill_pack ? pack_slot : '0;
  assign fill_line = LN_W'(int'(fill_way)*SLOTS + int'(fill_slot));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        wid_q[s] <= '0;
      end
    end else if (fill_valid) begin
      if (ev_fill_pack)
        vld_q[f_set][fill_line] <= 1'b1;
      else
        for (int s = 0; s < SLOTS; s++)
          vld_q[f_set][int'(fill_way)*SLOTS+s] <= (s == 0);
      wid_q[f_set][fill_way] <= fill_narrow;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      tag_q[f_set][fill_line] <= f_tag;
      for (int i = 0; i < LINE_WORDS; i++) begin
        if (fill_narrow)
          dat_q[f_set][fill_way][i][int'(fill_slot)*HALF_W +: HALF_W]
            <= fill_halves[i*HALF_W +: HALF_W];
        else
          dat_q[f_set][fill_way][i] <= fill_data[i*WORD_W +: WORD_W];
      end
    end
  end

  // ---------------- load side ----------------
  logic [SET_W-1:0] l_set;
  logic [TAG_W-1:0] l_tag;
  logic [IDX_W-1:0] l_idx;
  assign l_set = load_addr[BYTE_W+IDX_W +: SET_W];
  assign l_tag = load_addr[ADDR_W-1 -: TAG_W];
  assign l_idx = load_addr[BYTE_W +: IDX_W];

  logic [NL-1:0][TAG_W-1:0] set_tags;
  always_comb
    for (int l = 0; l < NL; l++) set_tags[l] = tag_q[l_set][l];

  logic            lk_hit;
  logic [LN_W-1:0] hit_line;

  nwc_tag_match #(.NL(NL), .TAG_W(TAG_W)) u_match (
    .tags     (set_tags),
    .valid    (vld_q[l_set]),
    .look_tag (l_tag),
    .hit      (lk_hit),
    .hit_line (hit_line)
  );

  logic [WAY_W-1:0]  hit_way;
  logic [SLOT_W-1:0] hit_slot;
  logic [WORD_W-1:0] rd_word, rd_val;
  logic              rd_cmp;

  assign hit_way  = WAY_W'(int'(hit_line) / SLOTS);
  assign hit_slot = SLOT_W'(int'(hit_line) % SLOTS);
  assign rd_word  = dat_q[l_set][hit_way][l_idx];
  assign rd_cmp   = wid_q[l_set][hit_way];
  assign rd_val   = rd_cmp ? sext_half(rd_word[int'(hit_slot)*HALF_W +: HALF_W])
                           : rd_word;

  logic resp_cmp_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_done  <= 1'b0;
      load_hit   <= 1'b0;
      load_data  <= '0;
      resp_cmp_q <= 1'b0;
    end else begin
      load_done  <= load_valid;
      load_hit   <= load_valid && lk_hit;
      load_data  <= (load_valid && lk_hit) ? rd_val : '0;
      resp_cmp_q <= load_valid && lk_hit && rd_cmp;
    end
  end

  // ---------------- recency ----------------
  logic             touch_en;
  logic [SET_W-1:0] touch_set;
  logic [LN_W-1:0]  touch_line;

  assign touch_en   = fill_valid || (load_valid && lk_hit);
  assign touch_set  = fill_valid ? f_set : l_set;
  assign touch_line = fill_valid ? fill_line : hit_line;

  nwc_recency #(.SETS(SETS), .WAYS(WAYS), .SLOTS(SLOTS)) u_rec (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (touch_en),
    .touch_set  (touch_set),
    .touch_line (touch_line),
    .sel_set    (f_set),
    .sel_valid  (vld_q[f_set]),
    .victim_way (victim_way)
  );

  // ---------------- assertions ----------------
  for (genvar s = 0; s < SETS; s++) begin : g_chk_set
    for (genvar w = 0; w < WAYS; w++) begin : g_chk_way
      assert_norm_slot1_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wid_q[s][w] |-> !vld_q[s][w*SLOTS+1]);
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_chk_pack
    assert_pack_keeps_mate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_fill_pack && fill_way == WAY_W'(w))
        |=> (&vld_q[$past(f_set)][w*SLOTS +: SLOTS]) && wid_q[$past(f_set)][w]);
  end

  assert_new_cmp_sets_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_new_cmp |=> wid_q[$past(f_set)][$past(fill_way)]);

  assert_norm_fill_clears_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_norm |=> !wid_q[$past(f_set)][$past(fill_way)]);

  assert_resp_sext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_hit && resp_cmp_q)
      |-> (load_data[WORD_W-1:HALF_W-1] == '0 || load_data[WORD_W-1:HALF_W-1] == '1));

  assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && !load_hit) |-> load_data == '0);

  assert_hit_has_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_hit |-> load_done);
endmodule

// File: tb/nwc_cache_tb.sv
`timescale 1ns/1ps
module nwc_cache_tb;
  localparam int SETS = 16;
  localparam int NL   = 4;
  localparam int LW   = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fill_valid = 1'b0;
  logic [31:0]  fill_addr = '0;
  logic [255:0] fill_data = '0;
  logic         load_valid = 1'b0;
  logic [31:0]  load_addr = '0;
  logic         load_done, load_hit;
  logic [31:0]  load_data;

  always #5 clk = ~clk;

  nwc_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .load_valid(load_valid), .load_addr(load_addr),
    .load_done(load_done), .load_hit(load_hit), .load_data(load_data)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // ---------------- behavioural model (time stamps) ----------------
  logic [22:0] m_tag   [SETS][NL];
  bit          m_vld   [SETS][NL];
  bit          m_wid   [SETS][2];
  logic [31:0] m_line  [SETS][NL][LW];
  longint      m_stamp [SETS][NL];
  longint      now_t = 0;

  bit          exp_done, exp_hit;
  logic [31:0] exp_data;

  function automatic bit m_narrow(logic [31:0] w);
    return ($signed(w) >= -32768) && ($signed(w) <= 32767);
  endfunction

  function automatic logic [31:0] mk_addr(int tag, int set, int idx, int off);
    return (32'(tag) << 9) | (32'(set) << 5) | (32'(idx) << 2) | 32'(off);
  endfunction

  function automatic int m_find(logic [31:0] a);
    int s = int'(a[8:5]);
    for (int l = 0; l < NL; l++)
      if (m_vld[s][l] && m_tag[s][l] == a[31:9]) return l;
    return -1;
  endfunction

  function automatic int m_victim(int s);
    int best = -1;
    longint best_t = 0;
    for (int w = 0; w < 2; w++)
      if (!m_vld[s][2*w] && !m_vld[s][2*w+1]) return w;
    for (int w = 0; w < 2; w++) begin
      longint young = -1;
      for (int k = 0; k < 2; k++)
        if (m_vld[s][2*w+k] && m_stamp[s][2*w+k] > young) young = m_stamp[s][2*w+k];
      if (best < 0 || young < best_t) begin best = w; best_t = young; end
    end
    return best;
  endfunction

  function automatic void m_fill(logic [31:0] a, logic [255:0] d);
    int s = int'(a[8:5]);
    bit nar = 1;
    int tgt = -1;
    for (int i = 0; i < LW; i++) if (!m_narrow(d[32*i +: 32])) nar = 0;
    if (nar)
      for (int w = 0; w < 2; w++)
        for (int k = 0; k < 2; k++)
          if (tgt < 0 && m_wid[s][w] && !m_vld[s][2*w+k]) tgt = 2*w + k;
    if (tgt < 0) begin
      int w = m_victim(s);
      tgt = 2*w;
      m_vld[s][2*w+1] = 0;
      m_wid[s][w] = nar;
    end
    m_vld[s][tgt] = 1;
    m_tag[s][tgt] = a[31:9];
    for (int i = 0; i < LW; i++) m_line[s][tgt][i] = d[32*i +: 32];
    now_t++;
    m_stamp[s][tgt] = now_t;
  endfunction

  task automatic check(bit ok, string req, logic [33:0] act, logic [33:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got done/hit/data %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, predict, compare at next negedge
  task automatic step(bit fv, logic [31:0] fa, logic [255:0] fd,
                      bit lv, logic [31:0] la, string req);
    int l;
    fill_valid = fv; fill_addr = fa; fill_data = fd;
    load_valid = lv; load_addr = la;
    exp_done = lv; exp_hit = 0; exp_data = '0;
    l = lv ? m_find(la) : -1;
    if (l >= 0) begin
      exp_hit  = 1;
      exp_data = m_line[int'(la[8:5])][l][int'(la[4:2])];
    end
    if (fv) m_fill(fa, fd);
    else if (l >= 0) begin now_t++; m_stamp[int'(la[8:5])][l] = now_t; end
    @(negedge clk);
    fill_valid = 0; load_valid = 0;
    check((load_done === exp_done) && (load_hit === exp_hit) && (load_data === exp_data),
          req, {load_done, load_hit, load_data}, {exp_done, exp_hit, exp_data});
  endtask

  task automatic expect_resp(bit hit, logic [31:0] data, string req);
    check(load_done === 1'b1 && load_hit === hit && load_data === data, req,
          {load_done, load_hit, load_data}, {1'b1, hit, data});
  endtask

  task automatic load(int tag, int set, int idx, string req);
    step(0, '0, '0, 1, mk_addr(tag, set, idx, idx % 4), req);
  endtask

  task automatic fill(int tag, int set, logic [255:0] d, string req);
    step(1, mk_addr(tag, set, 0, 0), d, 0, '0, req);
  endtask

  function automatic logic [255:0] mk_seq(logic [31:0] base, int wide_at, logic [31:0] wide_val);
    logic [255:0] d;
    for (int i = 0; i < LW; i++) d[32*i +: 32] = (i == wide_at) ? wide_val : base + 32'(i);
    return d;
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      for (int l = 0; l < NL; l++) begin m_vld[s][l] = 0; m_stamp[s][l] = 0; m_tag[s][l] = '0; end
      m_wid[s][0] = 0; m_wid[s][1] = 0;
    end
    repeat (3) @(negedge clk);
    // R10: reset state
    check(load_done === 1'b0 && load_hit === 1'b0, "R10",
          {load_done, load_hit, load_data}, {2'b00, load_data});
    rst_n = 1'b1;
    @(negedge clk);
    load(5, 3, 0, "R10");                       // empty cache misses
    expect_resp(0, 32'h0, "R5");

    // compressed line A, then its mate B in the same block
    fill(5, 3, mk_seq(32'hFFFF8000, -1, 0), "R1");
    load(5, 3, 0, "R3");
    expect_resp(1, 32'hFFFF8000, "R3");
    fill(6, 3, mk_seq(32'h00007FF0, -1, 0), "R7");
    load(6, 3, 7, "R2");
    expect_resp(1, 32'h00007FF7, "R2");
    load(5, 3, 7, "R2");
    expect_resp(1, 32'hFFFF8007, "R2");

    // wide line C goes to the empty way
    fill(7, 3, mk_seq(32'hFFFF8000, 3, 32'h00008000), "R8");
    load(7, 3, 3, "R1");
    expect_resp(1, 32'h00008000, "R1");
    load(7, 3, 0, "R4");
    load(5, 3, 1, "R9");                        // A becomes youngest
    fill(8, 3, mk_seq(32'h12345678, 0, 32'hFFFF7FFF), "R8");
    load(7, 3, 2, "R8");                        // C was the victim
    expect_resp(0, 32'h0, "R8");
    load(8, 3, 0, "R1");
    expect_resp(1, 32'hFFFF7FFF, "R1");
    load(8, 3, 2, "R3");
    load(5, 3, 4, "R9");

    // compressed E with a same-cycle load of E
    step(1, mk_addr(9, 3, 0, 0), mk_seq(32'h00000100, -1, 0), 1, mk_addr(9, 3, 2, 0), "R6");
    expect_resp(0, 32'h0, "R6");
    load(9, 3, 2, "R6");
    expect_resp(1, 32'h00000102, "R6");
    load(8, 3, 1, "R7");
    load(6, 3, 1, "R2");
    fill(10, 3, mk_seq(32'hFFFFFFF0, -1, 0), "R7");
    load(10, 3, 5, "R7");
    load(9, 3, 5, "R7");

    // fill while a hit lands: the hit must not refresh its line
    step(1, mk_addr(11, 3, 0, 0), mk_seq(32'h40000000, -1, 0), 1, mk_addr(6, 3, 0, 0), "R9");
    load(6, 3, 0, "R4");
    fill(12, 3, mk_seq(32'h50000000, -1, 0), "R9");
    load(9, 3, 0, "R9");
    load(11, 3, 0, "R9");
    load(12, 3, 0, "R9");

    // random phase on two sets and six tags
    for (int n = 0; n < 3000; n++) begin
      int set_a = ($urandom % 2 == 0) ? 2 : 9;
      int set_b = ($urandom % 2 == 0) ? 2 : 9;
      int tf    = 20 + int'($urandom % 6);
      int tl    = 20 + int'($urandom % 6);
      bit fv    = ($urandom % 10) < 4;
      bit lv    = ($urandom % 10) < 8;
      logic [255:0] d;
      logic [31:0] fa = mk_addr(tf, set_a, 0, 0);
      if (fv && m_find(fa) >= 0) fv = 0;
      for (int i = 0; i < LW; i++) begin
        logic [15:0] h = 16'($urandom);
        d[32*i +: 32] = {{16{h[15]}}, h};
      end
      if ($urandom % 10 < 4) begin
        int k = int'($urandom % LW);
        case ($urandom % 3)
          0: d[32*k +: 32] = 32'h00008000;
          1: d[32*k +: 32] = 32'hFFFF7FFF;
          default: d[32*k +: 32] = 32'($urandom) | 32'h00100000;
        endcase
      end
      step(fv, fa, d, lv, mk_addr(tl, set_b, int'($urandom % LW), int'($urandom % 4)),
           fv ? (lv ? "R6" : "R8") : "R5");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule